// File: doc/BRIEF.md
# Plug-and-Play Card Configuration Controller

This block is the card-side control logic for a legacy plug-and-play expansion bus. The host reaches the card's registers indirectly. It first writes a register index to an address port, and every later data write or data read acts on that index until the host writes a new one. The block tracks the card's state: waiting for the initiation key, sleeping, isolating, or being configured. It also holds the card select number and the selected logical device number.

Three registers carry commands. The control register takes self-clearing command bits that reset the logical devices, return the card to the key-wait state, or clear the card select number. The wake register moves a sleeping card whose select number matches the written byte. The card goes to isolation when the byte is zero and to configuration otherwise. The initiation-key detector is reduced to a single key-seen input. The block's outputs are the card state, a one-cycle request to reset the logical devices, and a one-cycle pulse that rewinds the resource-data byte pointer.

Top module: `pnp_card_ctrl`

## Requirements
- R1: While `rst` is high, and on the first clock after it, `state_o` is 0 (key wait), the card select number is 0, and both pulse outputs are low. State encoding: 0 key wait, 1 sleep, 2 isolation, 3 configuration.
- R2: A `key_seen` cycle in the key-wait state changes `state_o` to sleep on the next clock. In any other state `key_seen` has no effect.
- R3: A write on the address port latches `addr_data` as the register index on the next clock. Later data writes and data reads use that index until the address port is written again.
- R4: A data write to index 0x02 with bit 0 set raises `ldev_reset_o` for exactly one cycle after the write. The state and the card select number do not change.
- R5: A data write to index 0x02 with bit 1 set puts the card in key wait on the next clock. The card select number is kept.
- R6: A data write to index 0x02 with bit 2 set clears the card select number on the next clock.
- R7: A data write to index 0x03 in the sleep state, whose byte equals the card select number, moves the card to isolation if the byte is 0 and to configuration otherwise. A mismatching byte, or a wake write in any other state, changes nothing.
- R8: `res_ptr_clr_o` is high for exactly one cycle after each accepted wake write, and never at any other time.
- R9: A data write to index 0x06 loads the card select number, but only in isolation or configuration. A data read of index 0x06 returns the number.
- R10: With a single logical device (`NUM_LDEV` = 1), a data read of index 0x07 returns 0x00 and data writes to 0x07 are ignored.
- R11: The control command bits do not persist. After its one pulse, `ldev_reset_o` stays low until a new control write.
- R12: All outputs are registered. State and pulse outputs change on the clock that samples the write strobe. `rd_data` is loaded on the clock that samples `data_rd` and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| key_seen | input | 1 | Initiation key has been recognised |
| addr_wr | input | 1 | Host write strobe for the address port |
| addr_data | input | 8 | Register index written to the address port |
| data_wr | input | 1 | Host write strobe for the write-data port |
| wr_data | input | DATA_W | Write-data byte |
| data_rd | input | 1 | Host read strobe for the read port |
| rd_data | output | DATA_W | Registered read-port data |
| state_o | output | 2 | Current card state |
| ldev_reset_o | output | 1 | One-cycle request to reset all logical devices |
| res_ptr_clr_o | output | 1 | One-cycle resource-pointer rewind |

## Verification
The hardest case to reach from the ports is a wake to configuration with a nonzero select number. The select number can only be written while the card is isolating or configuring, so the card must first reach one of those states and then come back to sleep. The stimulus chains these steps: a key pulse, a zero wake into isolation, a select-number write, a control write that returns the card to key wait, a second key pulse, and finally a wake with the matching nonzero byte. Along this path the bench also sends wake and select-number writes in the wrong states, then reads the select number back to show they had no effect.

// File: rtl/pnp_cfg_pkg.sv
package pnp_cfg_pkg;
  localparam int IDX_W = 8;

  typedef enum logic [1:0] {
    ST_WAIT_KEY = 2'd0,
    ST_SLEEP    = 2'd1,
    ST_ISOLATE  = 2'd2,
    ST_CONFIG   = 2'd3
  } card_state_t;

  // register indices whose values the host software depends on
  localparam logic [IDX_W-1:0] IDX_CTRL = 8'h02;
  localparam logic [IDX_W-1:0] IDX_WAKE = 8'h03;
  localparam logic [IDX_W-1:0] IDX_CSN  = 8'h06;
  localparam logic [IDX_W-1:0] IDX_LDN  = 8'h07;

  // command bit positions inside the control byte
  localparam int CMD_LDEV_RST = 0;
  localparam int CMD_WAIT_KEY = 1;
  localparam int CMD_CSN_CLR  = 2;
endpackage

// File: rtl/pnp_index_latch.sv
module pnp_index_latch
  import pnp_cfg_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             addr_wr,
  input  logic [IDX_W-1:0] addr_data,
  output logic [IDX_W-1:0] index_q
);
  always_ff @(posedge clk) begin
    if (rst)          index_q <= '0;
    else if (addr_wr) index_q <= addr_data;
  end
endmodule

// File: rtl/pnp_card_fsm.sv
module pnp_card_fsm
  import pnp_cfg_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_seen,
  input  logic              ctrl_wr,
  input  logic              wake_wr,
  input  logic              csn_wr,
  input  logic [DATA_W-1:0] wr_data,
  output card_state_t       state_q,
  output logic [DATA_W-1:0] csn_q,
  output logic              ldev_reset_q,
  output logic              res_ptr_clr_q
);
  logic wake_hit;
  logic csn_open;

  assign wake_hit = wake_wr && (state_q == ST_SLEEP) && (wr_data == csn_q);
  assign csn_open = (state_q == ST_ISOLATE) || (state_q == ST_CONFIG);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= ST_WAIT_KEY;
      csn_q         <= '0;
      ldev_reset_q  <= 1'b0;
      res_ptr_clr_q <= 1'b0;
    end else begin
      ldev_reset_q  <= 1'b0;
      res_ptr_clr_q <= 1'b0;

      if (state_q == ST_WAIT_KEY && key_seen) state_q <= ST_SLEEP;

      if (wake_hit) begin
        state_q       <= (wr_data == '0) ? ST_ISOLATE : ST_CONFIG;
        res_ptr_clr_q <= 1'b1;
      end

      if (ctrl_wr) begin
        if (wr_data[CMD_LDEV_RST]) ldev_reset_q <= 1'b1;
        if (wr_data[CMD_WAIT_KEY]) state_q      <= ST_WAIT_KEY;
        if (wr_data[CMD_CSN_CLR])  csn_q        <= '0;
      end

      if (csn_wr && csn_open) csn_q <= wr_data;
    end
  end
endmodule

// File: rtl/pnp_ldn_sel.sv
module pnp_ldn_sel #(
  parameter int NUM_LDEV = 1,
  parameter int LDN_W    = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ldn_wr,
  input  logic [LDN_W-1:0] ldn_data,
  output logic [LDN_W-1:0] ldn_q
);
  generate
    if (NUM_LDEV > 1) begin : g_multi
      always_ff @(posedge clk) begin
        if (rst)         ldn_q <= '0;
        else if (ldn_wr) ldn_q <= ldn_data;
      end
    end else begin : g_single
      // one device: the selector stays at zero whatever is written
      always_ff @(posedge clk) begin
        if (rst || ldn_wr) ldn_q <= '0;
        else               ldn_q <= ldn_data & '0;
      end
    end
  endgenerate
endmodule

// File: rtl/pnp_card_ctrl.sv
module pnp_card_ctrl
  import pnp_cfg_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int NUM_LDEV = 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              key_seen,
  input  logic              addr_wr,
  input  logic [7:0]        addr_data,
  input  logic              data_wr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              data_rd,
  output logic [DATA_W-1:0] rd_data,
  output logic [1:0]        state_o,
  output logic              ldev_reset_o,
  output logic              res_ptr_clr_o
);
  localparam int LDN_W = (NUM_LDEV > 1) ? $clog2(NUM_LDEV) : 1;

  logic [IDX_W-1:0]  index_q;
  card_state_t       state_q;
  logic [DATA_W-1:0] csn_q;
  logic [LDN_W-1:0]  ldn_q;
  logic              ctrl_wr, wake_wr, csn_wr, ldn_wr;

  pnp_index_latch i_index (
    .clk(clk), .rst(rst), .addr_wr(addr_wr), .addr_data(addr_data),
    .index_q(index_q)
  );

  assign ctrl_wr = data_wr && (index_q == IDX_CTRL);
  assign wake_wr = data_wr && (index_q == IDX_WAKE);
  assign csn_wr  = data_wr && (index_q == IDX_CSN);
  assign ldn_wr  = data_wr && (index_q == IDX_LDN);

  pnp_card_fsm #(.DATA_W(DATA_W)) i_fsm (
    .clk(clk), .rst(rst), .key_seen(key_seen),
    .ctrl_wr(ctrl_wr), .wake_wr(wake_wr), .csn_wr(csn_wr),
    .wr_data(wr_data), .state_q(state_q), .csn_q(csn_q),
    .ldev_reset_q(ldev_reset_o), .res_ptr_clr_q(res_ptr_clr_o)
  );

  pnp_ldn_sel #(.NUM_LDEV(NUM_LDEV), .LDN_W(LDN_W)) i_ldn (
    .clk(clk), .rst(rst), .ldn_wr(ldn_wr),
    .ldn_data(wr_data[LDN_W-1:0]), .ldn_q(ldn_q)
  );

  assign state_o = state_q;

  // registered read port; write-only and unused indices read as zero
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= '0;
    end else if (data_rd) begin
      case (index_q)
        IDX_CSN: rd_data <= csn_q;
        IDX_LDN: rd_data <= {{(DATA_W-LDN_W){1'b0}}, ldn_q};
        default: rd_data <= '0;
      endcase
    end
  end
endmodule

// File: rtl/pnp_card_ctrl_chk.sv
module pnp_card_ctrl_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              key_seen,
  input logic [1:0]        state_o,
  input logic              ldev_reset_o,
  input logic              res_ptr_clr_o,
  input logic [DATA_W-1:0] csn_q
);
  logic rst_d;
  always_ff @(posedge clk) rst_d <= rst;

  // R1: the clock after reset shows the idle state
  always_ff @(posedge clk) begin
    if (rst_d) begin
      assert_reset_state_R1: assert (state_o == 2'd0 && csn_q == '0 &&
                                     !ldev_reset_o && !res_ptr_clr_o);
    end
  end

  assert_key_to_sleep_R2: assert property (@(posedge clk) disable iff (rst)
    (key_seen && state_o == 2'd0) |=> (state_o == 2'd1));

  assert_ldev_single_R4: assert property (@(posedge clk) disable iff (rst)
    ldev_reset_o |=> !ldev_reset_o);

  assert_zero_wake_R7: assert property (@(posedge clk) disable iff (rst)
    (state_o == 2'd2 && $past(state_o) == 2'd1) |-> (res_ptr_clr_o && csn_q == '0));

  assert_ptr_after_wake_R8: assert property (@(posedge clk) disable iff (rst)
    res_ptr_clr_o |-> ($past(state_o) == 2'd1 && state_o[1]));

  assert_ptr_single_R8: assert property (@(posedge clk) disable iff (rst)
    res_ptr_clr_o |=> !res_ptr_clr_o);
endmodule

bind pnp_card_ctrl pnp_card_ctrl_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst), .key_seen(key_seen), .state_o(state_o),
  .ldev_reset_o(ldev_reset_o), .res_ptr_clr_o(res_ptr_clr_o), .csn_q(csn_q)
);

// File: tb/test_pnp_card_ctrl.sv
`timescale 1ns/1ps
module test_pnp_card_ctrl;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       key_seen = 1'b0;
  logic       addr_wr = 1'b0;
  logic [7:0] addr_data = '0;
  logic       data_wr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       data_rd = 1'b0;
  logic [7:0] rd_data;
  logic [1:0] state_o;
  logic       ldev_reset_o;
  logic       res_ptr_clr_o;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  pnp_card_ctrl i_pnp_card_ctrl (
    .clk(clk), .rst(rst), .key_seen(key_seen), .addr_wr(addr_wr),
    .addr_data(addr_data), .data_wr(data_wr), .wr_data(wr_data),
    .data_rd(data_rd), .rd_data(rd_data), .state_o(state_o),
    .ldev_reset_o(ldev_reset_o), .res_ptr_clr_o(res_ptr_clr_o)
  );

  // vector: {key, index, data, expected state, expected csn}
  localparam int NV = 15;
  localparam logic [26:0] VEC [NV] = '{
    {1'b1, 8'h00, 8'h00, 2'd1, 8'h00},
    {1'b0, 8'h03, 8'h05, 2'd1, 8'h00},
    {1'b0, 8'h06, 8'h33, 2'd1, 8'h00},
    {1'b0, 8'h03, 8'h00, 2'd2, 8'h00},
    {1'b0, 8'h06, 8'h05, 2'd2, 8'h05},
    {1'b0, 8'h03, 8'h05, 2'd2, 8'h05},
    {1'b0, 8'h02, 8'h02, 2'd0, 8'h05},
    {1'b0, 8'h03, 8'h05, 2'd0, 8'h05},
    {1'b0, 8'h06, 8'h11, 2'd0, 8'h05},
    {1'b1, 8'h00, 8'h00, 2'd1, 8'h05},
    {1'b0, 8'h03, 8'h05, 2'd3, 8'h05},
    {1'b0, 8'h06, 8'h09, 2'd3, 8'h09},
    {1'b1, 8'h00, 8'h00, 2'd3, 8'h09},
    {1'b0, 8'h02, 8'h04, 2'd3, 8'h00},
    {1'b0, 8'h02, 8'h06, 2'd0, 8'h00}
  };

  task automatic check(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", req, got, exp);
    end
  endtask

  task automatic write_addr(input logic [7:0] a);
    addr_data = a; addr_wr = 1'b1;
    @(negedge clk); addr_wr = 1'b0;
  endtask

  task automatic write_data(input logic [7:0] d);
    wr_data = d; data_wr = 1'b1;
    @(negedge clk); data_wr = 1'b0;
  endtask

  task automatic read_reg(input logic [7:0] idx, output logic [7:0] v);
    write_addr(idx);
    data_rd = 1'b1;
    @(negedge clk); data_rd = 1'b0;
    v = rd_data;
  endtask

  task automatic pulse_key;
    key_seen = 1'b1;
    @(negedge clk); key_seen = 1'b0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    check("R1 state in reset", state_o, 0);
    check("R1 ldev pulse in reset", ldev_reset_o, 0);
    check("R1 ptr pulse in reset", res_ptr_clr_o, 0);
    rst = 1'b0;
    @(negedge clk);
    read_reg(8'h06, v);
    check("R1 csn after reset", v, 0);

    // table walk covering R2, R5, R6, R7, R9
    for (int i = 0; i < NV; i++) begin
      if (VEC[i][26]) pulse_key();
      else begin
        write_addr(VEC[i][25:18]);
        write_data(VEC[i][17:10]);
      end
      check($sformatf("R2,R5,R6,R7,R9 vector %0d state", i), state_o, VEC[i][9:8]);
      read_reg(8'h06, v);
      check($sformatf("R9 vector %0d csn", i), v, VEC[i][7:0]);
    end

    // build csn 7 in configuration, watching the pointer pulse (R8, R12)
    pulse_key();
    write_addr(8'h03); write_data(8'h00);
    check("R8 ptr pulse on zero wake", res_ptr_clr_o, 1);
    @(negedge clk);
    check("R8 ptr pulse one cycle", res_ptr_clr_o, 0);
    write_addr(8'h06); write_data(8'h07);
    write_addr(8'h02); write_data(8'h02);
    pulse_key();
    write_addr(8'h03); write_data(8'h07);
    check("R7 wake to config", state_o, 3);
    check("R8 ptr pulse on config wake", res_ptr_clr_o, 1);
    write_data(8'h07);
    check("R8 no pulse for wake outside sleep", res_ptr_clr_o, 0);

    // R4 and R11: logical-device reset
    write_addr(8'h02); write_data(8'h01);
    check("R4 ldev pulse", ldev_reset_o, 1);
    check("R4 state kept", state_o, 3);
    @(negedge clk);
    check("R11 ldev pulse cleared", ldev_reset_o, 0);
    read_reg(8'h06, v);
    check("R4 csn kept", v, 7);

    // R3: index persists across several accesses
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    check("R3 repeated read same index", rd_data, 7);
    write_addr(8'h05);
    data_rd = 1'b1; @(negedge clk); data_rd = 1'b0;
    check("R3 other index reads zero", rd_data, 0);

    // R10: single logical device
    write_addr(8'h07); write_data(8'h03);
    read_reg(8'h07, v);
    check("R10 ldn reads zero", v, 0);

    // R1: reset from configuration
    rst = 1'b1; @(negedge clk); rst = 1'b0;
    check("R1 state after mid-run reset", state_o, 0);
    read_reg(8'h06, v);
    check("R1 csn after mid-run reset", v, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule